// File: doc/BRIEF.md
# Masked PCI Configuration Register File

This block holds the 256-byte configuration space of a host-to-PCI bridge. Software reaches it through one byte-wide port with an 8-bit offset, a write strobe and a read strobe. Each offset has its own write rule. Some offsets take the written byte through a mask. One keeps forced-set bits. One clears status bits when a one is written to them. The subsystem identification bytes are guarded by a lock bit held in another register. Every other offset drops writes.

Reads always return the stored byte, one clock after the read strobe. The active-low reset loads the identification bytes, the subsystem identification and the other power-on defaults. Decoding of the bus cycle and every side effect of register contents lie outside this block.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, offsets 0x00..0x03 read 0xB9, 0x10, 0x31, 0x15. The subsystem bytes at 0x2C..0x2F read the same four values in the same order. Offsets 0x00..0x03 never change.
- R2: Other reset values: 0x04=0x06, 0x07=0x04, 0x08=0xB0, 0x0B=0x06, 0x0D=0x20, 0x52=0xF0, 0x54=0xFF, 0x55=0xFF, 0x59=0x20, 0x5A=0x20, 0x70=0x22. Within 0x60..0x6F, each even offset resets to 0x08 and each odd offset to 0x40. Every remaining offset resets to 0x00.
- R3: These offsets store the written byte unmasked: 0x04, 0x43..0x46, 0x48, 0x4A, 0x4C..0x4F, 0x50..0x52, 0x54..0x56, 0x59, 0x5A, 0x5C, 0x60..0x6F, 0x70, 0x71, 0x76, 0x77.
- R4: These offsets store the written byte ANDed with a mask (offset:mask): 0x05:0x01, 0x0D:0xF8, 0x83:0x10, 0x81:0x81, 0x80:0x84, 0x74:0x2B, 0x72:0x0F, 0x5F:0x7F, 0x5D:0x53, 0x5B:0x4F, 0x58:0x86, 0x57:0x60, 0x49:0x73, 0x47:0xFC, 0x42:0xF7, 0x40:0xF1.
- R5: A write to 0x41 stores (data AND 0xD6) OR 0x08, so bit 3 is set after any write.
- R6: At 0x07, each written one in bits 7..3 clears that stored bit. Written zeros and bits 2..0 of the data have no effect, so a write of 0xFF or 0x00 after reset leaves 0x04.
- R7: Writes to 0x2C..0x2F are stored unmasked only while bit 3 of offset 0x70 is 1. Otherwise they are dropped.
- R8: Writes to any offset not named in R3..R7 are dropped. Such an offset keeps its reset value, for example 0x00 stays 0xB9, and 0x06, 0x53 and 0x90 stay 0x00.
- R9: When re_i is high at a rising edge, rdata_o shows the stored byte of addr_i from the next cycle on. If the same edge also carries a write, the byte shown is the value from before that write. While re_i is low, rdata_o holds its value, even across writes.
- R10: Asserting rst_ni low at any time restores every R1/R2 value and clears rdata_o to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte offset for the read or write |
| we_i | input | 1 | Write strobe, takes effect on the rising edge |
| wdata_i | input | 8 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench writes all-ones and mixed patterns to masked offsets. A wrong mask shows up as extra or missing bits in the read-back. At 0x41 it writes zero, which catches a design that drops the forced bit. At 0x07 it writes all ones, which catches a design that stores the data or clears the wrong bits. The lock is tested in both states and after it is cleared again, so a gate wired to the wrong bit or inverted accepts a write that should have been dropped, or the reverse. Read-only identification bytes and unmapped offsets are also written, reads are checked to hold across writes made without a read strobe, and a reset in the middle of the run must bring back both the defaults and a zero read output.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_AW   = 8;
  localparam int CFG_DW   = 8;
  localparam int LOCK_OFF = 'h70;
  localparam int LOCK_BIT = 3;

  typedef enum logic [1:0] {
    K_RO   = 2'd0,
    K_MASK = 2'd1,
    K_W1C  = 2'd2,
    K_LOCK = 2'd3
  } wr_kind_e;

  typedef struct packed {
    wr_kind_e          kind;
    logic [CFG_DW-1:0] keep;
    logic [CFG_DW-1:0] force1;
  } wr_rule_t;

  function automatic wr_rule_t rule_of(input logic [CFG_AW-1:0] a);
    wr_rule_t r;
    r.kind   = K_RO;
    r.keep   = '0;
    r.force1 = '0;
    case (a) inside
      8'h04, 8'h43, 8'h44, 8'h45, 8'h46, 8'h48, 8'h4A,
      [8'h4C:8'h4F], 8'h50, 8'h51, 8'h52, 8'h54, 8'h55, 8'h56,
      8'h59, 8'h5A, 8'h5C, [8'h60:8'h6F], 8'h70, 8'h71,
      8'h76, 8'h77: begin
        r.kind = K_MASK; r.keep = 8'hFF;
      end
      8'h05: begin r.kind = K_MASK; r.keep = 8'h01; end
      8'h0D: begin r.kind = K_MASK; r.keep = 8'hF8; end
      8'h40: begin r.kind = K_MASK; r.keep = 8'hF1; end
      8'h41: begin r.kind = K_MASK; r.keep = 8'hD6; r.force1 = 8'h08; end
      8'h42: begin r.kind = K_MASK; r.keep = 8'hF7; end
      8'h47: begin r.kind = K_MASK; r.keep = 8'hFC; end
      8'h49: begin r.kind = K_MASK; r.keep = 8'h73; end
      8'h57: begin r.kind = K_MASK; r.keep = 8'h60; end
      8'h58: begin r.kind = K_MASK; r.keep = 8'h86; end
      8'h5B: begin r.kind = K_MASK; r.keep = 8'h4F; end
      8'h5D: begin r.kind = K_MASK; r.keep = 8'h53; end
      8'h5F: begin r.kind = K_MASK; r.keep = 8'h7F; end
      8'h72: begin r.kind = K_MASK; r.keep = 8'h0F; end
      8'h74: begin r.kind = K_MASK; r.keep = 8'h2B; end
      8'h80: begin r.kind = K_MASK; r.keep = 8'h84; end
      8'h81: begin r.kind = K_MASK; r.keep = 8'h81; end
      8'h83: begin r.kind = K_MASK; r.keep = 8'h10; end
      8'h07: begin r.kind = K_W1C;  r.keep = 8'hF8; end
      [8'h2C:8'h2F]: begin r.kind = K_LOCK; r.keep = 8'hFF; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [CFG_DW-1:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hB9;
      2'd1:    return 8'h10;
      2'd2:    return 8'h31;
      default: return 8'h15;
    endcase
  endfunction

  function automatic logic [CFG_DW-1:0] default_of(input logic [CFG_AW-1:0] a);
    case (a) inside
      [8'h00:8'h03], [8'h2C:8'h2F]: return id_byte(a[1:0]);
      8'h04:         return 8'h06;
      8'h07:         return 8'h04;
      8'h08:         return 8'hB0;
      8'h0B:         return 8'h06;
      8'h0D:         return 8'h20;
      8'h52:         return 8'hF0;
      8'h54, 8'h55:  return 8'hFF;
      8'h59, 8'h5A:  return 8'h20;
      8'h70:         return 8'h22;
      [8'h60:8'h6F]: return a[0] ? 8'h40 : 8'h08;
      default:       return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_write_policy.sv
module cfg_write_policy
  import cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_AW,
  parameter int DATA_W = CFG_DW
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic              lock_i,
  output logic [DATA_W-1:0] nxt_o
);
  wr_rule_t rule;

  always_comb begin
    rule = rule_of(addr_i);
    unique case (rule.kind)
      K_MASK:  nxt_o = (wdata_i & rule.keep) | rule.force1;
      K_W1C:   nxt_o = cur_i & ~(wdata_i & rule.keep);
      K_LOCK:  nxt_o = lock_i ? (wdata_i & rule.keep) : cur_i;
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_AW,
  parameter int DATA_W = CFG_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] nxt_i,
  output logic [DATA_W-1:0] cur_o,
  output logic              lock_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= default_of(ADDR_W'(i));
    end else if (we_i) begin
      mem_q[addr_i] <= nxt_i;
    end
  end

  assign cur_o  = mem_q[addr_i];
  assign lock_o = mem_q[LOCK_OFF][LOCK_BIT];
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= cur_i;
  end
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_AW,
  parameter int DATA_W = CFG_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cur_byte;
  logic [DATA_W-1:0] nxt_byte;
  logic              lock_bit;

  cfg_write_policy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_policy (
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cur_i   (cur_byte),
    .lock_i  (lock_bit),
    .nxt_o   (nxt_byte)
  );

  cfg_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .nxt_i  (nxt_byte),
    .cur_o  (cur_byte),
    .lock_o (lock_bit)
  );

  cfg_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .cur_i   (cur_byte),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/cfg_space_regs_chk.sv
module cfg_space_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       we_i,
  input logic       re_i,
  input logic [7:0] rdata_o,
  input logic [7:0] cur_byte,
  input logic [7:0] nxt_byte,
  input logic       lock_bit
);
  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  assert_id_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 8'h00) |=> rdata_o == 8'hB9);

  assert_id_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h00) |-> nxt_byte == cur_byte);

  assert_w1c_no_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h07) |-> (nxt_byte & ~cur_byte) == 8'h00);

  assert_force_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h41) |-> nxt_byte[3]);

  assert_mask_bit0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h05) |-> nxt_byte[7:1] == 7'd0);

  assert_lock_guard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[7:2] == 6'b001011 && !lock_bit) |-> nxt_byte == cur_byte);
endmodule

bind cfg_space_regs cfg_space_regs_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .cur_byte (cur_byte),
  .nxt_byte (nxt_byte),
  .lock_bit (lock_bit)
);

// File: tb/cfg_space_regs_bench.sv
`timescale 1ns/1ps
module cfg_space_regs_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       re_i = 1'b0;
  logic [7:0] rdata_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic re_seen = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk_i = ~clk_i;

  cfg_space_regs u_cfg_space_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .re_i    (re_i),
    .rdata_o (rdata_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; re_i = 1'b0;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1; we_i = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  // monitor: registered read data is valid at the negedge after the capture edge
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) re_seen <= 1'b0;
    else         re_seen <= re_i;

  always @(negedge clk_i) begin
    if (re_seen && exp_q.size() > 0) begin
      chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic drain;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    chk(rdata_o, 8'h00, "R10 rdata after reset");
    // R1 identification and subsystem defaults
    rd(8'h00, 8'hB9, "R1 id0"); rd(8'h01, 8'h10, "R1 id1");
    rd(8'h02, 8'h31, "R1 id2"); rd(8'h03, 8'h15, "R1 id3");
    rd(8'h2C, 8'hB9, "R1 sub0"); rd(8'h2D, 8'h10, "R1 sub1");
    rd(8'h2E, 8'h31, "R1 sub2"); rd(8'h2F, 8'h15, "R1 sub3");
    // R2 other defaults
    rd(8'h04, 8'h06, "R2 04"); rd(8'h07, 8'h04, "R2 07");
    rd(8'h08, 8'hB0, "R2 08"); rd(8'h0B, 8'h06, "R2 0B");
    rd(8'h0D, 8'h20, "R2 0D"); rd(8'h52, 8'hF0, "R2 52");
    rd(8'h54, 8'hFF, "R2 54"); rd(8'h55, 8'hFF, "R2 55");
    rd(8'h59, 8'h20, "R2 59"); rd(8'h5A, 8'h20, "R2 5A");
    rd(8'h70, 8'h22, "R2 70"); rd(8'h60, 8'h08, "R2 60");
    rd(8'h61, 8'h40, "R2 61"); rd(8'h6E, 8'h08, "R2 6E");
    rd(8'h6F, 8'h40, "R2 6F"); rd(8'h90, 8'h00, "R2 90");
    // R3 unmasked offsets
    wr(8'h44, 8'hA5); rd(8'h44, 8'hA5, "R3 44");
    wr(8'h04, 8'h5A); rd(8'h04, 8'h5A, "R3 04");
    wr(8'h6B, 8'hC3); rd(8'h6B, 8'hC3, "R3 6B");
    // R4 masked offsets
    wr(8'h05, 8'hFF); rd(8'h05, 8'h01, "R4 05");
    wr(8'h0D, 8'hFF); rd(8'h0D, 8'hF8, "R4 0D");
    wr(8'h40, 8'hFF); rd(8'h40, 8'hF1, "R4 40");
    wr(8'h83, 8'hFF); rd(8'h83, 8'h10, "R4 83");
    wr(8'h5D, 8'hAA); rd(8'h5D, 8'h02, "R4 5D");
    wr(8'h74, 8'h55); rd(8'h74, 8'h01, "R4 74");
    wr(8'h42, 8'hFF); rd(8'h42, 8'hF7, "R4 42");
    // R5 forced bit
    wr(8'h41, 8'h00); rd(8'h41, 8'h08, "R5 41 zero");
    wr(8'h41, 8'hFF); rd(8'h41, 8'hDE, "R5 41 ones");
    // R6 write-one-to-clear
    wr(8'h07, 8'hFF); rd(8'h07, 8'h04, "R6 07 ones");
    wr(8'h07, 8'h00); rd(8'h07, 8'h04, "R6 07 zero");
    // R7 lock
    wr(8'h2C, 8'h55); rd(8'h2C, 8'hB9, "R7 locked");
    wr(8'h70, 8'h08);
    wr(8'h2C, 8'h55); rd(8'h2C, 8'h55, "R7 unlocked");
    wr(8'h70, 8'h00);
    wr(8'h2D, 8'h77); rd(8'h2D, 8'h10, "R7 relocked");
    // R8 dropped writes
    wr(8'h00, 8'hFF); rd(8'h00, 8'hB9, "R8 00");
    wr(8'h06, 8'hFF); rd(8'h06, 8'h00, "R8 06");
    wr(8'h53, 8'hFF); rd(8'h53, 8'h00, "R8 53");
    wr(8'h90, 8'hFF); rd(8'h90, 8'h00, "R8 90");
    // R9 hold without read strobe, and old data on a same-edge read and write
    rd(8'h44, 8'hA5, "R9 pre");
    drain();
    wr(8'h44, 8'h3C);
    chk(rdata_o, 8'hA5, "R9 hold");
    @(negedge clk_i);
    addr_i = 8'h44; wdata_i = 8'h11; we_i = 1'b1; re_i = 1'b1;
    exp_q.push_back(8'h3C); tag_q.push_back("R9 rd-wr same edge");
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
    rd(8'h44, 8'h11, "R9 after");
    drain();
    // R10 reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk(rdata_o, 8'h00, "R10 rdata cleared");
    rst_ni = 1'b1;
    rd(8'h44, 8'h00, "R10 44"); rd(8'h2C, 8'hB9, "R10 2C");
    rd(8'h41, 8'h00, "R10 41"); rd(8'h04, 8'h06, "R10 04");
    drain();

    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d reads left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule